// File: doc/BRIEF.md
# Host Bridge Address Translator

This block sits between a local request port and a PCI-style bus master. A local read or write whose address falls in the upper-middle quarter of the 32-bit space is turned into a bus cycle. Every other address is answered at once as a local access, with no bus cycle. A small control register chooses, for all window accesses, between memory cycles and configuration cycles. The same register also supplies the two upper address bits that memory cycles put on the bus.

In configuration mode, the window address is read as a device number, a function number and a register offset. From these the block builds a configuration address that uses a one-hot device-select bit. Targets that cannot be reached are refused as not found and cause no bus cycle. Byte and halfword configuration reads return the addressed lanes shifted down to bit 0. Byte and halfword configuration writes are done as a dword read followed by a dword write of the merged value.

A state machine controls the sequencing. It has five states: ST_IDLE, ST_MEM, ST_CFG_RD, ST_CFG_WR and ST_RESP. Its transitions are:
- ST_IDLE stays put until a request is accepted. It then goes to ST_RESP for a local or refused access, to ST_MEM for a memory cycle, and to ST_CFG_RD for a legal configuration access.
- ST_MEM always goes to ST_RESP.
- ST_CFG_RD goes to ST_CFG_WR for a write and to ST_RESP for a read.
- ST_CFG_WR always goes to ST_RESP.
- ST_RESP always returns to ST_IDLE.

Top module: `hbx_top`

## Requirements
- R1: A request is local when req_addr[31:30] is not 2'b10. A local request gets a response with rsp_local=1, rsp_not_found=0 and rsp_rdata=0 one cycle after acceptance, and causes no bus cycle.
- R2: In memory mode, a window request drives one bus cycle with bus_cmd=2'b01. In that cycle, bus_addr = {control bits 3:2, req_addr[29:0]}, bus_write equals req_write, and bus_wdata equals req_wdata. A read returns bus_rdata unchanged on rsp_rdata.
- R3: Control bit 1 selects configuration cycles (bus_cmd=2'b10) for window requests. When it is clear, window requests produce memory cycles. The control register is written through ctl_we/ctl_wdata and resets to 0.
- R4: In configuration mode, the device is req_addr[15:11], the function is req_addr[10:8] and the offset is req_addr[7:0]. The configuration address is (1 << (13 + device)) | (function << 8) | (offset with bits 1:0 cleared).
- R5: A configuration request is refused when its device number exceeds 18 or its configuration address is at or above 0x00100000. A refused request gets rsp_not_found=1 and no bus cycle. A refused read returns 0xFFFFFFFF.
- R6: req_size selects the access width: 2'b00 is a byte, 2'b01 a halfword, and 2'b1x a dword. A configuration read returns (dword >> 8*offset[1:0]) masked to that width.
- R7: A configuration write first reads the dword and then writes, at the same address, the old value with the addressed lanes replaced by the low bytes of req_wdata shifted up by 8*offset[1:0].
- R8: The bus cycle type appears in the cycle after acceptance. The response pulses for one cycle, in the cycle after the last bus cycle. req_ready is low from acceptance until the response has been given.
- R9: After reset the block is idle with req_ready=1, no bus cycle and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control bits 3:1 (bit 1 selects configuration mode; bits 3:2 are the memory upper address bits) |
| req_valid | input | 1 | Request strobe, accepted when req_ready is high |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width |
| req_addr | input | 32 | Local address |
| req_wdata | input | 32 | Write data, low-aligned |
| bus_valid | output | 1 | A bus cycle is issued this cycle |
| bus_cmd | output | 2 | Cycle type: 01 memory, 10 configuration |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | 32 | Translated bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Target read data, valid during bus_valid |
| rsp_valid | output | 1 | Response pulse |
| rsp_local | output | 1 | Request was outside the window |
| rsp_not_found | output | 1 | Configuration target refused |
| rsp_rdata | output | 32 | Read result |

## Verification
The assertions check several properties on every cycle: that a configuration address always carries exactly one select bit below 0x00100000, that each configuration write directly follows a read of the same address, that refused and local responses are never preceded by a bus cycle, and that req_ready stays low while the bus is busy. Only the bench scenarios can show the values themselves. These are the memory address built from the control field, the exact one-hot position for each device, the refusal boundary between device 6 and device 7 and above 18, the lane extraction for every size and offset, and the merged write dword. The bench compares each of these against its own model of a target whose data is a fixed function of the address.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_MEM  = 2'b01,
        CYC_CFG  = 2'b10
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM,
        ST_CFG_RD,
        ST_CFG_WR,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic        local_hit;
        logic        refused;
        logic [31:0] bus_addr;
    } route_t;

endpackage

// File: rtl/hbx_route.sv
module hbx_route
    import hbx_pkg::*;
#(
    parameter int          DEV_W     = 5,
    parameter int          FN_W      = 3,
    parameter int          OFF_W     = 8,
    parameter int          IDSEL_LSB = 13,
    parameter int          MAX_DEV   = 18,
    parameter logic [1:0]  WIN_TOP   = 2'b10,
    parameter logic [31:0] CFG_SPAN  = 32'h0010_0000
) (
    input  logic [31:0] req_addr,
    input  logic        cfg_sel,
    input  logic [1:0]  hi_bits,
    output route_t      route
);
    localparam int FN_LSB  = OFF_W;
    localparam int DEV_LSB = OFF_W + FN_W;

    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  func;
    logic [OFF_W-1:0] off;
    logic [5:0]       shamt;
    logic [31:0]      one_hot;
    logic [31:0]      cfg_addr;

    always_comb begin
        dev      = req_addr[DEV_LSB +: DEV_W];
        func     = req_addr[FN_LSB +: FN_W];
        off      = req_addr[OFF_W-1:0];
        shamt    = 6'(IDSEL_LSB) + 6'(dev);
        one_hot  = 32'd1 << shamt;
        cfg_addr = one_hot | (32'(func) << FN_LSB) | 32'({off[OFF_W-1:2], 2'b00});

        route.local_hit = (req_addr[31:30] != WIN_TOP);
        route.refused   = (dev > DEV_W'(MAX_DEV)) || (cfg_addr >= CFG_SPAN);
        route.bus_addr  = cfg_sel ? cfg_addr : {hi_bits, req_addr[29:0]};
    end
endmodule

// File: rtl/hbx_lanes.sv
module hbx_lanes (
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] rd_word,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_extract,
    output logic [31:0] wr_merged
);
    logic [31:0] mask;
    logic [4:0]  sh;

    always_comb begin
        unique case (size)
            2'b00:   mask = 32'h0000_00FF;
            2'b01:   mask = 32'h0000_FFFF;
            default: mask = 32'hFFFF_FFFF;
        endcase
        sh         = {lane, 3'b000};
        rd_extract = (rd_word >> sh) & mask;
        wr_merged  = (rd_word & ~(mask << sh)) | ((wr_data & mask) << sh);
    end
endmodule

// File: rtl/hbx_top.sv
module hbx_top
    import hbx_pkg::*;
#(
    parameter int          IDSEL_LSB = 13,
    parameter int          MAX_DEV   = 18,
    parameter logic [1:0]  WIN_TOP   = 2'b10,
    parameter logic [31:0] CFG_SPAN  = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [3:1]  ctl_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        bus_valid,
    output logic [1:0]  bus_cmd,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    output logic        rsp_valid,
    output logic        rsp_local,
    output logic        rsp_not_found,
    output logic [31:0] rsp_rdata
);
    state_e      st_q, st_d;
    logic [3:1]  ctl_q;
    route_t      route;
    logic        accept;

    logic [31:0] addr_q, wdata_q, merged_q, rdata_q;
    logic [1:0]  size_q, lane_q;
    logic        wr_q, loc_q, nf_q;
    logic [31:0] rd_extract, wr_merged;

    hbx_route #(
        .IDSEL_LSB (IDSEL_LSB),
        .MAX_DEV   (MAX_DEV),
        .WIN_TOP   (WIN_TOP),
        .CFG_SPAN  (CFG_SPAN)
    ) u_route (
        .req_addr (req_addr),
        .cfg_sel  (ctl_q[1]),
        .hi_bits  (ctl_q[3:2]),
        .route    (route)
    );

    hbx_lanes u_lanes (
        .size       (size_q),
        .lane       (lane_q),
        .rd_word    (bus_rdata),
        .wr_data    (wdata_q),
        .rd_extract (rd_extract),
        .wr_merged  (wr_merged)
    );

    assign accept = req_valid && (st_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (route.local_hit)     st_d = ST_RESP;
                    else if (!ctl_q[1])      st_d = ST_MEM;
                    else if (route.refused)  st_d = ST_RESP;
                    else                     st_d = ST_CFG_RD;
                end
            end
            ST_MEM:    st_d = ST_RESP;
            ST_CFG_RD: st_d = wr_q ? ST_CFG_WR : ST_RESP;
            ST_CFG_WR: st_d = ST_RESP;
            ST_RESP:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // request capture and read-data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            merged_q <= '0;
            rdata_q  <= '0;
            size_q   <= '0;
            lane_q   <= '0;
            wr_q     <= 1'b0;
            loc_q    <= 1'b0;
            nf_q     <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= route.bus_addr;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                size_q  <= req_size;
                lane_q  <= req_addr[1:0];
                loc_q   <= route.local_hit;
                nf_q    <= !route.local_hit && ctl_q[1] && route.refused;
                rdata_q <= (!route.local_hit && ctl_q[1] && route.refused && !req_write)
                           ? '1 : '0;
            end
            if (st_q == ST_MEM)
                rdata_q <= wr_q ? '0 : bus_rdata;
            if (st_q == ST_CFG_RD) begin
                merged_q <= wr_merged;
                rdata_q  <= wr_q ? '0 : rd_extract;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        bus_valid     = 1'b0;
        bus_cmd       = CYC_NONE;
        bus_write     = 1'b0;
        bus_addr      = '0;
        bus_wdata     = '0;
        rsp_valid     = 1'b0;
        rsp_local     = 1'b0;
        rsp_not_found = 1'b0;
        rsp_rdata     = '0;
        unique case (st_q)
            ST_MEM: begin
                bus_valid = 1'b1;
                bus_cmd   = CYC_MEM;
                bus_write = wr_q;
                bus_addr  = addr_q;
                bus_wdata = wr_q ? wdata_q : '0;
            end
            ST_CFG_RD: begin
                bus_valid = 1'b1;
                bus_cmd   = CYC_CFG;
                bus_addr  = addr_q;
            end
            ST_CFG_WR: begin
                bus_valid = 1'b1;
                bus_cmd   = CYC_CFG;
                bus_write = 1'b1;
                bus_addr  = addr_q;
                bus_wdata = merged_q;
            end
            ST_RESP: begin
                rsp_valid     = 1'b1;
                rsp_local     = loc_q;
                rsp_not_found = nf_q;
                rsp_rdata     = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hbx_chk.sv
module hbx_chk #(
    parameter logic [31:0] CFG_SPAN = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        bus_valid,
    input logic [1:0]  bus_cmd,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic        rsp_valid,
    input logic        rsp_local,
    input logic        rsp_not_found
);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R3
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_cmd == 2'b01 || bus_cmd == 2'b10));

    // R4
    idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'b10) |->
            ($countones(bus_addr[31:13]) == 1 && bus_addr < CFG_SPAN));

    // R7
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'b10 && bus_write) |->
            ($past(bus_valid && bus_cmd == 2'b10 && !bus_write) &&
             $past(bus_addr) == bus_addr));

    // R5
    refused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_not_found) |-> !$past(bus_valid));

    // R1
    local_quick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_local) |->
            ($past(req_valid && req_ready) && !$past(bus_valid)));
endmodule

bind hbx_top hbx_chk #(.CFG_SPAN(CFG_SPAN)) u_hbx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .bus_valid     (bus_valid),
    .bus_cmd       (bus_cmd),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .rsp_valid     (rsp_valid),
    .rsp_local     (rsp_local),
    .rsp_not_found (rsp_not_found)
);

// File: tb/tb_hbx_top.sv
module tb_hbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [3:1]  ctl_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic [1:0]  bus_cmd;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        rsp_valid;
    logic        rsp_local;
    logic        rsp_not_found;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [3:1] ctl_m = '0;

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1 ^ {4{a[7:0]}};
    endfunction

    assign bus_rdata = pat(bus_addr);

    hbx_top dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [3:1] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_m = v;
    endtask

    task automatic run(input logic [31:0] a, input logic wr,
                       input logic [1:0] sz, input logic [31:0] wd);
        logic [4:0]  dev;
        logic [63:0] one;
        logic [31:0] ca, e_addr, e_rd, mask, old, merged;
        logic [4:0]  sh;
        logic        loc, cfg, refd;
        int          e_n, n, k;
        logic [31:0] ev_addr[4];
        logic [1:0]  ev_cmd[4];
        logic        ev_wr[4];
        logic [31:0] ev_wd[4];
        string       tag;

        loc  = (a[31:30] != 2'b10);
        cfg  = !loc && ctl_m[1];
        dev  = a[15:11];
        one  = 64'd1 << (13 + int'(dev));
        ca   = one[31:0] | (32'(a[10:8]) << 8) | {24'd0, a[7:2], 2'b00};
        refd = cfg && (dev > 5'd18 || ca >= 32'h0010_0000);
        e_addr = cfg ? ca : {ctl_m[3:2], a[29:0]};
        mask = (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
        sh   = {a[1:0], 3'b000};
        old  = pat(e_addr);
        merged = (old & ~(mask << sh)) | ((wd & mask) << sh);
        if (loc)       begin e_n = 0; e_rd = 0; end
        else if (!cfg) begin e_n = 1; e_rd = wr ? 0 : old; end
        else if (refd) begin e_n = 0; e_rd = wr ? 0 : 32'hFFFF_FFFF; end
        else           begin e_n = wr ? 2 : 1; e_rd = wr ? 0 : ((old >> sh) & mask); end
        tag = loc ? "R1" : !cfg ? "R2" : refd ? "R5" : wr ? "R7" : (sz[1] ? "R4" : "R6");

        @(negedge clk);
        chk("R8 ready before", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        for (k = 0; k < 8; k++) begin
            if (bus_valid && n < 4) begin
                ev_addr[n] = bus_addr; ev_cmd[n] = bus_cmd;
                ev_wr[n] = bus_write; ev_wd[n] = bus_wdata;
                n++;
            end
            if (rsp_valid) break;
            chk("R8 ready low", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
        chk({tag, " bus cycles"}, n, e_n);
        chk("R8 latency", k, e_n);
        chk({tag, " local"}, {31'd0, rsp_local}, {31'd0, loc});
        chk({tag, " notfound"}, {31'd0, rsp_not_found}, {31'd0, refd});
        chk({tag, " rdata"}, rsp_rdata, e_rd);
        if (n >= 1 && e_n >= 1) begin
            chk("R3 cmd", {30'd0, ev_cmd[0]}, cfg ? 32'd2 : 32'd1);
            chk({tag, " addr"}, ev_addr[0], e_addr);
            chk({tag, " dir"}, {31'd0, ev_wr[0]}, {31'd0, !cfg && wr});
            if (!cfg && wr) chk("R2 wdata", ev_wd[0], wd);
        end
        if (n >= 2 && e_n == 2) begin
            chk("R7 wr addr", ev_addr[1], ca);
            chk("R7 wr dir", {30'd0, ev_cmd[1], ev_wr[1]}, 32'b101);
            chk("R7 merged", ev_wd[1], merged);
        end
    endtask

    initial begin
        #1_600_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R9
        chk("R9 ready", {31'd0, req_ready}, 32'd1);
        chk("R9 bus", {31'd0, bus_valid}, 32'd0);
        chk("R9 rsp", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;

        // R9 control cleared: memory mode, top bits zero
        run(32'h8000_0010, 1'b0, 2'b10, 0);
        run(32'h7FFF_FFFF, 1'b0, 2'b10, 0);
        run(32'hC000_0000, 1'b1, 2'b10, 32'h1234_5678);
        run(32'hBFFF_FFFC, 1'b1, 2'b10, 32'hCAFE_F00D);
        set_ctl(3'b110);
        run(32'h8123_4568, 1'b0, 2'b10, 0);
        set_ctl(3'b111);
        run(32'h8000_0000 | (32'd6 << 11) | (32'd7 << 8) | 32'hFC, 1'b0, 2'b10, 0);
        run(32'h8000_0000 | (32'd7 << 11), 1'b0, 2'b10, 0);
        run(32'h8000_0000 | (32'd19 << 11), 1'b0, 2'b10, 0);
        run(32'h8000_0000 | (32'd19 << 11), 1'b1, 2'b10, 32'h1);
        run(32'h8000_0000 | (32'd0 << 11) | 32'h03, 1'b0, 2'b00, 0);
        run(32'h8000_0000 | (32'd2 << 11) | 32'h0E, 1'b0, 2'b01, 0);
        run(32'h8000_0000 | (32'd3 << 11) | 32'h41, 1'b1, 2'b00, 32'hFFFF_FFAB);
        run(32'h8000_0000 | (32'd1 << 11) | 32'h12, 1'b1, 2'b01, 32'h0000_BEEF);
        run(32'h4000_0000 | (32'd1 << 11), 1'b0, 2'b10, 0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            if (i % 25 == 0) set_ctl(3'($urandom()));
            a = $urandom();
            if ($urandom() % 4 != 0) a[31:30] = 2'b10;
            if ($urandom() % 2 == 0) a[15:11] = 5'($urandom() % 9);
            run(a, 1'($urandom()), 2'($urandom()), $urandom());
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule